// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers single-cycle event pulses from the converter, digital-input, output-driver, temperature and supply-watch logic. It keeps them in a 16-bit sticky flag register and raises one interrupt line when any flag is set whose mask bit is clear. The same block also holds two 20-port status vectors, one for captured digital-input edges and one for per-port overcurrent events. The host reads each of these vectors in two halves: a low half for ports 0..15 and a high half for ports 16..19. The host reads over an external bus, and that bus appears here only as single-cycle read strobes. Every register is visible on an output port. A strobe is asserted in the cycle in which the host samples the value, and the clearing it causes takes effect at that cycle's clock edge.

Most flags clear as soon as the flag register is read. Four flags need a two-step acknowledge before they clear. These are converter data ready, input event, input event missed and overcurrent. First the flag register must be read while the flag is set. After that, both halves of the matching status vector must be read, in either order. The data-ready flag pairs with a converter status vector that sits outside this block, so only its two read strobes come in here. Digital-input edges are detected per port under a 2-bit mode. Each temperature channel produces a new-sample flag and two threshold flags.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the flag register, both port status vectors and `irq_o` are all zero.
- R2: A pulse on `adc_done_i`, `adc_ready_i`, `adc_missed_i`, or `supply_low_i` sets flag bit 0, 1, 2 or 15 respectively at the next clock edge. A set flag stays set until its clear condition occurs.
- R3: Flag bits 0, 2 and 6..15 clear at the clock edge of a cycle with `rd_irq_i` high.
- R4: Flag bits 1 (paired with the converter strobes), 3 and 4 (input strobes) and 5 (overcurrent strobes) do not clear on `rd_irq_i` alone. Such a flag clears once it is armed and both half strobes of its pair have been seen while armed, in either order or in the same cycle. Half reads made while the flag is not armed do not count toward the clear.
- R5: Each input port has a 2-bit mode in `gpi_mode_i[2p+1:2p]`: 0 never, 1 rising, 2 falling, 3 both edges. A matching edge sets that port's bit in `gpi_stat_o` and flag bit 3 at the clock edge that samples the new level. A level already present when reset is released produces no event.
- R6: An input event on a port whose `gpi_stat_o` bit is already set, and which is not cleared by a half read in that cycle, sets flag bit 4.
- R7: `rd_gpi_lo_i` or `rd_oc_lo_i` clears ports 0..15 of its status vector. `rd_gpi_hi_i` or `rd_oc_hi_i` clears ports 16..19. This happens whether or not any flag is armed.
- R8: A pulse on `oc_evt_i[p]` sets `oc_stat_o[p]` and flag bit 5.
- R9: Channel c (0 internal, 1 and 2 external) has its flags at bits 6+3c (new sample), 7+3c (sample unsigned-less than its low threshold) and 8+3c (sample unsigned-greater than its high threshold). The flags are set on a valid sample, and equality sets neither threshold flag.
- R10: `irq_o` is high exactly when some flag bit is set while its `irq_mask_i` bit is 0.
- R11: An event arriving in the same cycle as a read that would clear its flag or port bit wins, and the bit stays set.
- R12: A flag is armed for the two-step clear only by a flag-register read made while that flag is set. A flag that rises after the read needs a new register read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_done_i | input | 1 | Conversion or sweep finished pulse |
| adc_ready_i | input | 1 | New converter data pulse |
| adc_missed_i | input | 1 | Converter data overwritten unread pulse |
| supply_low_i | input | 1 | Supply below limit pulse |
| oc_evt_i | input | 20 | Per-port overcurrent pulses |
| gpi_lvl_i | input | 20 | Per-port digital input levels |
| gpi_mode_i | input | 40 | Per-port 2-bit edge mode |
| temp_vld_i | input | 3 | Per-channel sample valid |
| temp_smp_i | input | 36 | Samples, 12 bits per channel |
| temp_lo_i | input | 36 | Low thresholds, 12 bits per channel |
| temp_hi_i | input | 36 | High thresholds, 12 bits per channel |
| irq_mask_i | input | 16 | Mask, 1 disables a flag |
| rd_irq_i | input | 1 | Flag register read strobe |
| rd_adc_lo_i | input | 1 | Converter status low-half read strobe |
| rd_adc_hi_i | input | 1 | Converter status high-half read strobe |
| rd_gpi_lo_i | input | 1 | Input status low-half read strobe |
| rd_gpi_hi_i | input | 1 | Input status high-half read strobe |
| rd_oc_lo_i | input | 1 | Overcurrent status low-half read strobe |
| rd_oc_hi_i | input | 1 | Overcurrent status high-half read strobe |
| irq_stat_o | output | 16 | Sticky flag register |
| gpi_stat_o | output | 20 | Captured input events |
| oc_stat_o | output | 20 | Captured overcurrent events |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can land on the same clock edge: a new event sets a bit, and a host read clears that same bit. The stimulus table provokes this for a single-clear flag by pulsing the supply monitor in the cycle that reads the flag register. A directed step provokes it for a two-step flag by pulsing an overcurrent port while both overcurrent halves are read to complete an armed clear. In both cases the bench judges the outcome from the registers one edge later. The freshly hit bit must still be set, and every other bit that the read targeted must be gone.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int FLAG_W  = 16;
  localparam int N_TEMP  = 3;
  localparam int N_DEFER = 4;
  localparam int N_GRP   = 3;

  localparam int B_ADC_DONE = 0;
  localparam int B_ADC_RDY  = 1;
  localparam int B_ADC_MISS = 2;
  localparam int B_GPI_EVT  = 3;
  localparam int B_GPI_MISS = 4;
  localparam int B_DAC_OC   = 5;
  localparam int B_TEMP0    = 6;
  localparam int B_SUPPLY   = 15;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  // flag position of each two-step flag
  function automatic int defer_bit(input int k);
    case (k)
      0:       return B_ADC_RDY;
      1:       return B_GPI_EVT;
      2:       return B_GPI_MISS;
      default: return B_DAC_OC;
    endcase
  endfunction

  // status-vector pair: 0 converter, 1 input, 2 overcurrent
  function automatic int defer_grp(input int k);
    case (k)
      0:       return 0;
      1, 2:    return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic is_defer(input int b);
    return (b == B_ADC_RDY) || (b == B_GPI_EVT) || (b == B_GPI_MISS) || (b == B_DAC_OC);
  endfunction
endpackage

// File: rtl/gpi_edge_det.sv
`timescale 1ns/1ps
module gpi_edge_det
  import irq_pkg::*;
#(
  parameter int NPORT = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPORT-1:0]   lvl_i,
  input  logic [2*NPORT-1:0] mode_i,
  output logic [NPORT-1:0]   evt_o
);
  logic [NPORT-1:0] prev_q;
  logic             primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= lvl_i;
      primed_q <= 1'b1;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    edge_mode_e md;
    logic       rise, fall, hit;
    assign md   = edge_mode_e'(mode_i[2*p +: 2]);
    assign rise = lvl_i[p] & ~prev_q[p];
    assign fall = ~lvl_i[p] & prev_q[p];
    always_comb begin
      case (md)
        EDGE_RISE: hit = rise;
        EDGE_FALL: hit = fall;
        EDGE_ANY:  hit = rise | fall;
        default:   hit = 1'b0;
      endcase
    end
    assign evt_o[p] = primed_q & hit;

    AST_EVT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[p] |-> (lvl_i[p] != prev_q[p])); // R5
    AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[2*p +: 2] == 2'd0) |-> !evt_o[p]); // R5
  end
endmodule

// File: rtl/port_stat.sv
`timescale 1ns/1ps
module port_stat #(
  parameter int NPORT = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] set_i,
  input  logic [NPORT-1:0] clr_i,
  output logic [NPORT-1:0] stat_o
);
  logic [NPORT-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= set_i | (stat_q & ~clr_i);
  end
  assign stat_o = stat_q;

  AST_PORT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((stat_o & $past(set_i)) == $past(set_i))); // R11
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0) |=> ((stat_o & $past(stat_o)) == $past(stat_o))); // R7
endmodule

// File: rtl/temp_cmp.sv
`timescale 1ns/1ps
module temp_cmp #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [TW-1:0] smp_i,
  input  logic [TW-1:0] lo_thr_i,
  input  logic [TW-1:0] hi_thr_i,
  output logic [2:0]    flags_o
);
  // flags_o: bit0 new sample, bit1 below low, bit2 above high
  assign flags_o[0] = vld_i;
  assign flags_o[1] = vld_i && (smp_i < lo_thr_i);
  assign flags_o[2] = vld_i && (smp_i > hi_thr_i);

  AST_LO_HI_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && (lo_thr_i <= hi_thr_i)) |-> !(flags_o[1] && flags_o[2])); // R9
  AST_THR_NEEDS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[1] || flags_o[2]) |-> flags_o[0]); // R9
endmodule

// File: rtl/two_stage_clr.sv
`timescale 1ns/1ps
module two_stage_clr (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic rd_lo_i,
  input  logic rd_hi_i,
  output logic armed_o,
  output logic done_o
);
  logic armed_q, lo_q, hi_q;

  assign done_o  = armed_q & (lo_q | rd_lo_i) & (hi_q | rd_hi_i);
  assign armed_o = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      lo_q    <= 1'b0;
      hi_q    <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      lo_q    <= 1'b0;
      hi_q    <= 1'b0;
    end else if (done_o) begin
      armed_q <= 1'b0;
      lo_q    <= 1'b0;
      hi_q    <= 1'b0;
    end else if (armed_q) begin
      lo_q <= lo_q | rd_lo_i;
      hi_q <= hi_q | rd_hi_i;
    end
  end

  AST_DISARM_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !arm_i) |=> !armed_q); // R4
endmodule

// File: rtl/irq_status_ctrl.sv
`timescale 1ns/1ps
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int NPORT = 20,
  parameter int LO_W  = 16,
  parameter int TW    = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adc_done_i,
  input  logic                  adc_ready_i,
  input  logic                  adc_missed_i,
  input  logic                  supply_low_i,
  input  logic [NPORT-1:0]      oc_evt_i,
  input  logic [NPORT-1:0]      gpi_lvl_i,
  input  logic [2*NPORT-1:0]    gpi_mode_i,
  input  logic [N_TEMP-1:0]     temp_vld_i,
  input  logic [N_TEMP*TW-1:0]  temp_smp_i,
  input  logic [N_TEMP*TW-1:0]  temp_lo_i,
  input  logic [N_TEMP*TW-1:0]  temp_hi_i,
  input  logic [FLAG_W-1:0]     irq_mask_i,
  input  logic                  rd_irq_i,
  input  logic                  rd_adc_lo_i,
  input  logic                  rd_adc_hi_i,
  input  logic                  rd_gpi_lo_i,
  input  logic                  rd_gpi_hi_i,
  input  logic                  rd_oc_lo_i,
  input  logic                  rd_oc_hi_i,
  output logic [FLAG_W-1:0]     irq_stat_o,
  output logic [NPORT-1:0]      gpi_stat_o,
  output logic [NPORT-1:0]      oc_stat_o,
  output logic                  irq_o
);
  localparam int HI_W = NPORT - LO_W;
  localparam logic [NPORT-1:0] LO_MASK = {{HI_W{1'b0}}, {LO_W{1'b1}}};
  localparam logic [NPORT-1:0] HI_MASK = ~LO_MASK;

  logic [FLAG_W-1:0]  stat_q, set_v, clr_v;
  logic [NPORT-1:0]   gpi_evt, gpi_clr, oc_clr;
  logic               gpi_miss;
  logic [2:0]         tflag [N_TEMP];
  logic [N_DEFER-1:0] done, armed;
  logic [N_GRP-1:0]   grp_lo, grp_hi;

  // ---------------- digital input edges and port status ----------------
  gpi_edge_det #(.NPORT(NPORT)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (gpi_lvl_i),
    .mode_i (gpi_mode_i),
    .evt_o  (gpi_evt)
  );

  assign gpi_clr  = ({NPORT{rd_gpi_lo_i}} & LO_MASK) | ({NPORT{rd_gpi_hi_i}} & HI_MASK);
  assign oc_clr   = ({NPORT{rd_oc_lo_i}}  & LO_MASK) | ({NPORT{rd_oc_hi_i}}  & HI_MASK);
  assign gpi_miss = |(gpi_evt & gpi_stat_o & ~gpi_clr);

  port_stat #(.NPORT(NPORT)) u_gpi_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (gpi_evt),
    .clr_i  (gpi_clr),
    .stat_o (gpi_stat_o)
  );

  port_stat #(.NPORT(NPORT)) u_oc_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (oc_evt_i),
    .clr_i  (oc_clr),
    .stat_o (oc_stat_o)
  );

  // ---------------- temperature channels ----------------
  for (genvar c = 0; c < N_TEMP; c++) begin : g_temp
    temp_cmp #(.TW(TW)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld_i    (temp_vld_i[c]),
      .smp_i    (temp_smp_i[c*TW +: TW]),
      .lo_thr_i (temp_lo_i[c*TW +: TW]),
      .hi_thr_i (temp_hi_i[c*TW +: TW]),
      .flags_o  (tflag[c])
    );
  end

  // ---------------- flag set vector ----------------
  always_comb begin
    set_v             = '0;
    set_v[B_ADC_DONE] = adc_done_i;
    set_v[B_ADC_RDY]  = adc_ready_i;
    set_v[B_ADC_MISS] = adc_missed_i;
    set_v[B_GPI_EVT]  = |gpi_evt;
    set_v[B_GPI_MISS] = gpi_miss;
    set_v[B_DAC_OC]   = |oc_evt_i;
    set_v[B_SUPPLY]   = supply_low_i;
    for (int c = 0; c < N_TEMP; c++) set_v[B_TEMP0 + 3*c +: 3] = tflag[c];
  end

  // ---------------- two-step acknowledge trackers ----------------
  assign grp_lo = {rd_oc_lo_i, rd_gpi_lo_i, rd_adc_lo_i};
  assign grp_hi = {rd_oc_hi_i, rd_gpi_hi_i, rd_adc_hi_i};

  for (genvar k = 0; k < N_DEFER; k++) begin : g_defer
    localparam int FB = defer_bit(k);
    localparam int GP = defer_grp(k);
    logic arm;
    assign arm = rd_irq_i & stat_q[FB] & ~done[k];
    two_stage_clr u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_i   (arm),
      .rd_lo_i (grp_lo[GP]),
      .rd_hi_i (grp_hi[GP]),
      .armed_o (armed[k]),
      .done_o  (done[k])
    );

    AST_DEFER_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[FB] && !armed[k]) |=> stat_q[FB]); // R4
  end

  // ---------------- flag register ----------------
  always_comb begin
    clr_v = {FLAG_W{rd_irq_i}};
    for (int k = 0; k < N_DEFER; k++) clr_v[defer_bit(k)] = done[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= set_v | (stat_q & ~clr_v);
  end

  assign irq_stat_o = stat_q;
  assign irq_o      = |(stat_q & ~irq_mask_i);

  for (genvar b = 0; b < FLAG_W; b++) begin : g_chk
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[b] |=> stat_q[b]); // R11
    if (!is_defer(b)) begin : g_single
      AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[b] && !rd_irq_i) |=> stat_q[b]); // R3
    end
  end

  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask_i == '1) |-> !irq_o); // R10
endmodule

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/1ps
module sim_irq_status_ctrl;
  localparam int NP = 20;
  localparam int TW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adc_done_i = 0, adc_ready_i = 0, adc_missed_i = 0, supply_low_i = 0;
  logic [NP-1:0]   oc_evt_i = '0;
  logic [NP-1:0]   gpi_lvl_i = '0;
  logic [2*NP-1:0] gpi_mode_i = '0;
  logic [2:0]      temp_vld_i = '0;
  logic [3*TW-1:0] temp_smp_i = '0, temp_lo_i = '0, temp_hi_i = '0;
  logic [15:0]     irq_mask_i = '0;
  logic rd_irq_i = 0, rd_adc_lo_i = 0, rd_adc_hi_i = 0;
  logic rd_gpi_lo_i = 0, rd_gpi_hi_i = 0, rd_oc_lo_i = 0, rd_oc_hi_i = 0;
  logic [15:0]   irq_stat_o;
  logic [NP-1:0] gpi_stat_o, oc_stat_o;
  logic          irq_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  irq_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .adc_done_i(adc_done_i), .adc_ready_i(adc_ready_i), .adc_missed_i(adc_missed_i),
    .supply_low_i(supply_low_i), .oc_evt_i(oc_evt_i),
    .gpi_lvl_i(gpi_lvl_i), .gpi_mode_i(gpi_mode_i),
    .temp_vld_i(temp_vld_i), .temp_smp_i(temp_smp_i),
    .temp_lo_i(temp_lo_i), .temp_hi_i(temp_hi_i),
    .irq_mask_i(irq_mask_i), .rd_irq_i(rd_irq_i),
    .rd_adc_lo_i(rd_adc_lo_i), .rd_adc_hi_i(rd_adc_hi_i),
    .rd_gpi_lo_i(rd_gpi_lo_i), .rd_gpi_hi_i(rd_gpi_hi_i),
    .rd_oc_lo_i(rd_oc_lo_i), .rd_oc_hi_i(rd_oc_hi_i),
    .irq_stat_o(irq_stat_o), .gpi_stat_o(gpi_stat_o), .oc_stat_o(oc_stat_o),
    .irq_o(irq_o)
  );

  // row: {pulses[3:0] = supply,missed,ready,done ; rd_irq ; mask ; expected flags ; expected irq}
  localparam logic [37:0] VEC [10] = '{
    {4'b0001, 1'b0, 16'h0000, 16'h0001, 1'b1},
    {4'b0000, 1'b0, 16'h0000, 16'h0001, 1'b1},
    {4'b0000, 1'b1, 16'h0000, 16'h0000, 1'b0},
    {4'b0010, 1'b0, 16'h0000, 16'h0002, 1'b1},
    {4'b0000, 1'b1, 16'h0000, 16'h0002, 1'b1},
    {4'b1100, 1'b0, 16'h0000, 16'h8006, 1'b1},
    {4'b1000, 1'b1, 16'h0000, 16'h8002, 1'b1},
    {4'b0000, 1'b0, 16'h8002, 16'h8002, 1'b0},
    {4'b0000, 1'b0, 16'h0002, 16'h8002, 1'b1},
    {4'b0000, 1'b1, 16'h0000, 16'h0002, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock edge passes; returns at the following falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    adc_done_i = 0; adc_ready_i = 0; adc_missed_i = 0; supply_low_i = 0;
    oc_evt_i = '0; temp_vld_i = '0; rd_irq_i = 0;
    rd_adc_lo_i = 0; rd_adc_hi_i = 0; rd_gpi_lo_i = 0; rd_gpi_hi_i = 0;
    rd_oc_lo_i = 0; rd_oc_hi_i = 0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 50000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // modes: p0 never, p3 rising, p5 both, p8 both (held high through reset), p17 falling
    gpi_mode_i[2*3 +: 2]  = 2'd1;
    gpi_mode_i[2*5 +: 2]  = 2'd3;
    gpi_mode_i[2*8 +: 2]  = 2'd3;
    gpi_mode_i[2*17 +: 2] = 2'd2;
    gpi_lvl_i[8] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1 flags", 32'(irq_stat_o), 32'h0);
    chk("R1 R5 input status", 32'(gpi_stat_o), 32'h0);
    chk("R1 overcurrent status", 32'(oc_stat_o), 32'h0);
    chk("R1 irq", 32'(irq_o), 32'h0);

    // ---- table walk: R2 R3 R10 R11 ----
    for (int i = 0; i < 10; i++) begin
      {supply_low_i, adc_missed_i, adc_ready_i, adc_done_i} = VEC[i][37:34];
      rd_irq_i   = VEC[i][33];
      irq_mask_i = VEC[i][32:17];
      step();
      idle();
      chk($sformatf("R2 R3 R11 row %0d flags", i), 32'(irq_stat_o), 32'(VEC[i][16:1]));
      chk($sformatf("R10 row %0d irq", i), 32'(irq_o), 32'(VEC[i][0]));
    end
    irq_mask_i = '0;
    rd_adc_lo_i = 1; step(); idle();
    chk("R4 one half only", 32'(irq_stat_o), 32'h0002);
    rd_adc_hi_i = 1; step(); idle();
    chk("R4 both halves", 32'(irq_stat_o), 32'h0000);

    // ---- R4: halves before arming do not count, order hi then lo ----
    adc_ready_i = 1; step(); idle();
    rd_adc_lo_i = 1; rd_adc_hi_i = 1; step(); idle();
    chk("R4 unarmed halves", 32'(irq_stat_o), 32'h0002);
    rd_irq_i = 1; step(); idle();
    chk("R4 register read alone", 32'(irq_stat_o), 32'h0002);
    rd_adc_hi_i = 1; step(); idle();
    rd_adc_lo_i = 1; step(); idle();
    chk("R4 reverse order", 32'(irq_stat_o), 32'h0000);

    // ---- R12: read while clear does not arm ----
    rd_irq_i = 1; step(); idle();
    adc_ready_i = 1; step(); idle();
    rd_adc_lo_i = 1; rd_adc_hi_i = 1; step(); idle();
    chk("R12 no arm from earlier read", 32'(irq_stat_o), 32'h0002);
    rd_irq_i = 1; step(); idle();
    rd_adc_lo_i = 1; rd_adc_hi_i = 1; step(); idle();
    chk("R4 same-cycle halves", 32'(irq_stat_o), 32'h0000);

    // ---- R5 R6 R7: input edges ----
    gpi_lvl_i[0] = 1; gpi_lvl_i[3] = 1; gpi_lvl_i[17] = 1; step();
    chk("R5 rise modes", 32'(gpi_stat_o), 32'h00008);
    chk("R5 flag", 32'(irq_stat_o), 32'h0008);
    gpi_lvl_i[17] = 0; step();
    chk("R5 falling", 32'(gpi_stat_o), 32'h20008);
    gpi_lvl_i[5] = 1; step();
    chk("R5 both up", 32'(gpi_stat_o), 32'h20028);
    gpi_lvl_i[5] = 0; step();
    chk("R6 missed", 32'(irq_stat_o), 32'h0018);
    rd_gpi_lo_i = 1; step(); idle();
    chk("R7 low half clear", 32'(gpi_stat_o), 32'h20000);
    chk("R4 flags kept", 32'(irq_stat_o), 32'h0018);
    rd_irq_i = 1; step(); idle();
    rd_gpi_hi_i = 1; step(); idle();
    chk("R7 high half clear", 32'(gpi_stat_o), 32'h00000);
    chk("R4 after one armed half", 32'(irq_stat_o), 32'h0018);
    rd_gpi_lo_i = 1; step(); idle();
    chk("R4 input flags cleared", 32'(irq_stat_o), 32'h0000);

    // ---- R8 R11: overcurrent ----
    oc_evt_i[19] = 1; step(); idle();
    chk("R8 port", 32'(oc_stat_o), 32'h80000);
    chk("R8 flag", 32'(irq_stat_o), 32'h0020);
    rd_irq_i = 1; step(); idle();
    rd_oc_lo_i = 1; rd_oc_hi_i = 1; oc_evt_i[2] = 1; step(); idle();
    chk("R11 port bit kept", 32'(oc_stat_o), 32'h00004);
    chk("R11 deferred flag kept", 32'(irq_stat_o), 32'h0020);
    rd_irq_i = 1; step(); idle();
    rd_oc_lo_i = 1; rd_oc_hi_i = 1; step(); idle();
    chk("R8 cleared port", 32'(oc_stat_o), 32'h0);
    chk("R8 cleared flag", 32'(irq_stat_o), 32'h0);

    // ---- R9: temperature ----
    for (int c = 0; c < 3; c++) begin
      temp_lo_i[c*TW +: TW] = 12'd100;
      temp_hi_i[c*TW +: TW] = 12'd200;
    end
    temp_smp_i = {12'd300, 12'd150, 12'd50}; temp_vld_i = 3'b111; step(); idle();
    chk("R9 compare", 32'(irq_stat_o), 32'h52C0);
    rd_irq_i = 1; step(); idle();
    chk("R3 temp cleared", 32'(irq_stat_o), 32'h0);
    temp_smp_i = {12'd200, 12'd200, 12'd100}; temp_vld_i = 3'b111; step(); idle();
    chk("R9 equality", 32'(irq_stat_o), 32'h1240);
    chk("R10 irq on", 32'(irq_o), 32'h1);
    rd_irq_i = 1; step(); idle();
    chk("R3 final clear", 32'(irq_stat_o), 32'h0);

    finish_run();
  end
endmodule